// File: doc/BRIEF.md
# Packed Saturating Fractional Multiplier

This block multiplies two 64-bit packed words lane by lane in signed fractional arithmetic. A mode input selects the lane size. In the narrow mode the word holds eight Q7 lanes. In the wide mode it holds four Q15 lanes. Each lane of operand A is multiplied by the lane in the same position of operand B. The double-width product is brought back to the lane's Q format by truncation, which drops the low fraction bits. The lane result is written to the same bit positions it was read from. The operand pair made of two most-negative values is the only pair whose true product cannot be represented. That lane is clamped to the largest positive value, and the overflow indication is raised.

An execution pipeline uses the block as one registered stage. It presents both operands, the mode and an input strobe in one cycle. The packed result and an output strobe appear on the next cycle. A sticky overflow flag gathers saturation events from any number of operations and keeps them until the pipeline pulses the clear input.

Top module: `simd_qmul`

## Requirements
- R1: With `lane_sel` = 0 (eight 8-bit lanes), each output byte equals bits [14:7] of the signed 16-bit product of the same-position bytes of `op_a` and `op_b`. This is an arithmetic right shift by 7 bits with truncation.
- R2: With `lane_sel` = 1 (four 16-bit lanes), each output halfword equals bits [30:15] of the signed 32-bit product of the same-position halfwords.
- R3: Lane i of the selected width occupies bits [W*i+W-1 : W*i] of `op_a`, `op_b` and `result`. The same 64-bit inputs therefore give different results and different flag behaviour depending on `lane_sel`.
- R4: In 8-bit mode, a lane whose two inputs are both 0x80 produces 0x7F and sets `ovf_flag`.
- R5: In 16-bit mode, a lane whose two inputs are both 0x8000 produces 0x7FFF and sets `ovf_flag`.
- R6: Every other operand pair leaves `ovf_flag` unchanged. This includes one most-negative input paired with any other value, and 0x80 bytes in 16-bit mode.
- R7: `result` and `out_valid` are registered. `out_valid` is high exactly one cycle after a cycle with `in_valid` high. `result` keeps its value after a cycle with `in_valid` low.
- R8: `ovf_flag` stays set until a cycle with `ovf_clr` high clears it. When a saturating operation arrives in the same cycle as `ovf_clr`, the flag is set.
- R9: A synchronous active-high `rst` clears `result` to zero and clears both `out_valid` and `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| lane_sel | input | 1 | 0: eight Q7 lanes, 1: four Q15 lanes |
| op_a | input | 64 | Packed multiplicand |
| op_b | input | 64 | Packed multiplier |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| result | output | 64 | Packed Q-format products |
| ovf_flag | output | 1 | Sticky saturation indication |

## Verification
The assertions assume that `rst` is held from time zero until the first clock edge. They also assume that `lane_sel` and the operands are defined whenever `in_valid` is high. The bench drives every input from the first instant and changes them only on the falling edge, so both assumptions hold. In 8-bit mode the bench sweeps every byte pair across the lanes. In 16-bit mode it mixes random halfwords with a corner set that contains 0x8000, so the saturating pair and the pairs next to it all appear. Clear pulses are applied both on idle cycles and together with saturating operations.

// File: rtl/simd_qmul_pkg.sv
package simd_qmul_pkg;

    localparam int WORD_W = 64;
    localparam int NARROW_W = 8;
    localparam int WIDE_W = 16;

    typedef enum logic {
        LANE_Q7  = 1'b0,
        LANE_Q15 = 1'b1
    } lane_mode_e;

    // Result word and saturation summary carried from the lane array to the stage.
    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              sat;
    } mul_word_t;

    function automatic lane_mode_e decode_mode(input logic sel);
        return sel ? LANE_Q15 : LANE_Q7;
    endfunction

    // Next value of the sticky flag; a new event takes precedence over a clear.
    function automatic logic sticky_next(input logic cur, input logic event_hit,
                                         input logic clr);
        logic nxt;
        if (event_hit)
            nxt = 1'b1;
        else if (clr)
            nxt = 1'b0;
        else
            nxt = cur;
        return nxt;
    endfunction

endpackage

// File: rtl/simd_qmul_lane.sv
module simd_qmul_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         sat
);
    localparam int PW = 2 * W;
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

    logic signed [PW-1:0] prod;

    always_comb begin
        prod = $signed(a) * $signed(b);
        sat  = (a == MOST_NEG) && (b == MOST_NEG);
        if (sat)
            y = MOST_POS;
        else
            y = prod[PW-2:W-1];
    end
endmodule

// File: rtl/simd_qmul_array.sv
module simd_qmul_array
    import simd_qmul_pkg::*;
#(
    parameter int DW = WORD_W,
    parameter int NW = NARROW_W,
    parameter int WW = WIDE_W
) (
    input  lane_mode_e        mode,
    input  logic [DW-1:0]     a,
    input  logic [DW-1:0]     b,
    output mul_word_t         out
);
    localparam int N_NARROW = DW / NW;
    localparam int N_WIDE   = DW / WW;

    logic [DW-1:0]       y_narrow;
    logic [DW-1:0]       y_wide;
    logic [N_NARROW-1:0] sat_narrow;
    logic [N_WIDE-1:0]   sat_wide;

    for (genvar i = 0; i < N_NARROW; i++) begin : g_narrow
        simd_qmul_lane #(.W(NW)) u_lane (
            .a   (a[i*NW +: NW]),
            .b   (b[i*NW +: NW]),
            .y   (y_narrow[i*NW +: NW]),
            .sat (sat_narrow[i])
        );
    end

    for (genvar j = 0; j < N_WIDE; j++) begin : g_wide
        simd_qmul_lane #(.W(WW)) u_lane (
            .a   (a[j*WW +: WW]),
            .b   (b[j*WW +: WW]),
            .y   (y_wide[j*WW +: WW]),
            .sat (sat_wide[j])
        );
    end

    always_comb begin
        if (mode == LANE_Q15) begin
            out.data = y_wide;
            out.sat  = |sat_wide;
        end else begin
            out.data = y_narrow;
            out.sat  = |sat_narrow;
        end
    end
endmodule

// File: rtl/simd_qmul_stage.sv
module simd_qmul_stage
    import simd_qmul_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic          clr,
    input  mul_word_t     nxt,
    output logic          out_valid,
    output logic [DW-1:0] data_q,
    output logic          flag_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            data_q    <= '0;
            flag_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                data_q <= nxt.data;
            flag_q <= sticky_next(flag_q, in_valid && nxt.sat, clr);
        end
    end

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r7_idle_no_valid: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    a_r7_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(data_q));
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (in_valid && nxt.sat) |=> flag_q);
    a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!flag_q && !(in_valid && nxt.sat)) |=> !flag_q);
endmodule

// File: rtl/simd_qmul.sv
module simd_qmul
    import simd_qmul_pkg::*;
#(
    parameter int DATA_W = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              lane_sel,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic              ovf_clr,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic              ovf_flag
);
    lane_mode_e mode;
    mul_word_t  comb_out;

    assign mode = decode_mode(lane_sel);

    simd_qmul_array #(.DW(DATA_W)) u_array (
        .mode (mode),
        .a    (op_a),
        .b    (op_b),
        .out  (comb_out)
    );

    simd_qmul_stage #(.DW(DATA_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .clr       (ovf_clr),
        .nxt       (comb_out),
        .out_valid (out_valid),
        .data_q    (result),
        .flag_q    (ovf_flag)
    );

    a_r4_q7_clamp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !lane_sel && op_a[7:0] == 8'h80 && op_b[7:0] == 8'h80)
        |=> (result[7:0] == 8'h7F && ovf_flag));
    a_r5_q15_clamp: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_sel && op_a[15:0] == 16'h8000 && op_b[15:0] == 16'h8000)
        |=> (result[15:0] == 16'h7FFF && ovf_flag));
    a_r1_zero_lane: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !lane_sel && op_a[7:0] == 8'h00) |=> (result[7:0] == 8'h00));
    a_r9_reset_clears: assert property (@(posedge clk)
        rst |=> (!out_valid && !ovf_flag && result == '0));
endmodule

// File: tb/simd_qmul_tb.sv
module simd_qmul_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        lane_sel = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic        ovf_clr = 1'b0;
    logic        out_valid;
    logic [63:0] result;
    logic        ovf_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit exp_ovf = 0;
    logic [63:0] last_res = '0;

    always #2 clk = ~clk;

    simd_qmul u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sel(lane_sel),
        .op_a(op_a), .op_b(op_b), .ovf_clr(ovf_clr),
        .out_valid(out_valid), .result(result), .ovf_flag(ovf_flag)
    );

    // Arithmetic model: sign-extend each lane, multiply, floor-divide by 2^(W-1).
    function automatic logic [63:0] model(input bit wide, input logic [63:0] a,
                                          input logic [63:0] b, output bit s);
        int w = wide ? 16 : 8;
        longint span = longint'(1) << w;
        longint half = longint'(1) << (w - 1);
        logic [63:0] r = '0;
        s = 0;
        for (int i = 0; i < 64 / w; i++) begin
            longint va = longint'((a >> (i * w)) & 64'(span - 1));
            longint vb = longint'((b >> (i * w)) & 64'(span - 1));
            longint p;
            longint q;
            if (va >= half) va = va - span;
            if (vb >= half) vb = vb - span;
            if (va == -half && vb == -half) begin
                q = half - 1;
                s = 1;
            end else begin
                p = va * vb;
                q = p >>> (w - 1);
            end
            r = r | ((64'(q) & 64'(span - 1)) << (i * w));
        end
        return r;
    endfunction

    task automatic fail_line(input string req, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        errors++;
        $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    endtask

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!cond) fail_line(req, what, act, exp);
    endtask

    // One operation: drive on the falling edge, sample one cycle later.
    task automatic op(input bit wide, input logic [63:0] a, input logic [63:0] b,
                      input bit clr, input string req);
        bit s;
        logic [63:0] e;
        e = model(wide, a, b, s);
        in_valid = 1'b1; lane_sel = wide; op_a = a; op_b = b; ovf_clr = clr;
        exp_ovf = s ? 1'b1 : (clr ? 1'b0 : exp_ovf);
        @(negedge clk);
        check(result == e && out_valid, req, "result", result, e);
        check(ovf_flag == exp_ovf, req, "ovf_flag", 64'(ovf_flag), 64'(exp_ovf));
        last_res = e;
        in_valid = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic idle(input bit clr, input string req);
        in_valid = 1'b0; ovf_clr = clr; op_a = 64'hDEAD_BEEF_0BAD_F00D;
        if (clr) exp_ovf = 1'b0;
        @(negedge clk);
        check(!out_valid, req, "out_valid idle", 64'(out_valid), 64'd0);
        check(result == last_res, req, "result hold", result, last_res);
        check(ovf_flag == exp_ovf, req, "ovf_flag idle", 64'(ovf_flag), 64'(exp_ovf));
        ovf_clr = 1'b0;
    endtask

    function automatic logic [15:0] pick16();
        logic [15:0] corner [6] = '{16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'h0000, 16'h8001};
        if ($urandom % 3 == 0) return corner[$urandom % 6];
        return 16'($urandom);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(result == '0 && !out_valid && !ovf_flag, "R9", "reset state",
              result, 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // R1/R4: every byte pair appears, lane k gets b = j*8+k
        for (int av = 0; av < 256; av++) begin
            for (int j = 0; j < 32; j++) begin
                logic [63:0] a, b;
                for (int k = 0; k < 8; k++) begin
                    a[k*8 +: 8] = 8'(av);
                    b[k*8 +: 8] = 8'(j * 8 + k);
                end
                op(1'b0, a, b, 1'b0, "R1");
            end
        end
        check(ovf_flag, "R4", "flag after 0x80*0x80", 64'(ovf_flag), 64'd1);

        // R8: flag holds over idle cycles, then clears
        idle(1'b0, "R8");
        idle(1'b0, "R7");
        idle(1'b1, "R8");

        // R6: most-negative paired with other values does not saturate
        op(1'b0, 64'h8080_8080_8080_8080, 64'h7F81_0001_FF7E_4002, 1'b0, "R6");
        op(1'b1, 64'h8000_8000_8000_8000, 64'h7FFF_8001_FFFF_0001, 1'b0, "R6");
        // R3: 0x80 bytes in wide mode are not the saturating pair
        op(1'b1, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 1'b0, "R3");
        check(!ovf_flag, "R6", "no saturation", 64'(ovf_flag), 64'd0);
        // R3: same words in narrow mode saturate every lane
        op(1'b0, 64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 1'b0, "R3");
        idle(1'b1, "R8");

        // R5: saturating pair in each wide lane position
        for (int l = 0; l < 4; l++) begin
            logic [63:0] a = 64'h1234_5678_9ABC_DEF0;
            logic [63:0] b = 64'h0FED_CBA9_8765_4321;
            a[l*16 +: 16] = 16'h8000;
            b[l*16 +: 16] = 16'h8000;
            op(1'b1, a, b, 1'b0, "R5");
            idle(1'b1, "R8");
        end

        // R2: wide-mode sweep with corner-heavy random halfwords
        for (int n = 0; n < 6000; n++) begin
            logic [63:0] a, b;
            for (int l = 0; l < 4; l++) begin
                a[l*16 +: 16] = pick16();
                b[l*16 +: 16] = pick16();
            end
            op(1'b1, a, b, (n % 7) == 0, "R2");
        end

        // R8: saturation in the same cycle as a clear leaves the flag set
        idle(1'b1, "R8");
        op(1'b0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080, 1'b1, "R8");
        check(ovf_flag, "R8", "set over clear", 64'(ovf_flag), 64'd1);

        // R9: reset in mid run
        in_valid = 1'b1; op_a = '1; op_b = '1;
        rst = 1'b1;
        @(negedge clk);
        check(result == '0 && !out_valid && !ovf_flag, "R9", "mid-run reset",
              result, 64'd0);
        rst = 1'b0; in_valid = 1'b0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule